// File: doc/BRIEF.md
# I2C Channel Select Controller

This block is an I2C target that holds one 8-bit selection byte. The low four bits of that byte switch four downstream bus channels on or off, singly or in any mix. An upstream master addresses the block, writes a new selection and ends the transfer with a stop condition. Only at that stop do the registered channel-enable outputs move to the new value. The master can also read back the enables that are currently applied.

The serial clock and data lines come from the bus as raw samples. Each passes through a synchroniser and a counting glitch filter before start, stop and clock edges are found. The block answers by pulling data low through an open-drain enable. Three strap inputs set the low bits of the target address. An active-low reset, which also models power-on reset, clears the enables and drops any transfer in progress.

Top module: `i2c_chan_sel`

## Requirements
- R1: While `rst_n` is low, `chan_en` is 0 and `sda_low` is 0 (data released). The reset also clears an applied selection.
- R2: The target address is 7 bits: 1110 in the top four bits, then `strap[2:0]`. The eighth bit is read (1) or write (0). A matching address is acknowledged by holding data low through the high phase of the ninth clock. Any other address gets no acknowledge and changes nothing.
- R3: Each written data byte is acknowledged. Its bit n (n = 0..3) enables channel n, and bits 7..4 are ignored.
- R4: A written selection does not reach `chan_en` while the transfer is open. It is applied when the next stop condition is seen.
- R5: When several data bytes come in one write, only the last complete byte is applied at the stop.
- R6: A read returns, MSB first, four zero bits followed by the applied `chan_en[3:0]`. A master ACK makes the block send the byte again, and a master NACK ends the read.
- R7: A repeated start begins a fresh address phase. A selection still pending from before it is kept and applied at the final stop, and a read in between returns the old applied value.
- R8: A stop in the middle of a byte ends the transfer and changes nothing. A start in the middle of a byte begins a new address phase.
- R9: If reset cuts a write off before its stop, the pending selection is dropped. A later stop leaves `chan_en` at 0.
- R10: A pulse on either line that is shorter than `FILT_CYCLES` clock cycles is ignored. A stray clock pulse adds no bit, and a stray data pulse during clock high makes no stop.
- R11: A write transfer that is acknowledged but carries no data byte leaves `chan_en` unchanged at its stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low reset, also used as power-on reset |
| strap | input | 3 | Low three address bits |
| scl_in | input | 1 | Raw bus clock level |
| sda_in | input | 1 | Raw bus data level |
| sda_low | output | 1 | Open-drain enable: 1 pulls data low |
| chan_en | output | 4 | Registered enable, one bit per downstream channel |

## Verification
Most faults in the controller's state show up at the ports within one byte. A bit counter that is off by one, or a wrong shift, moves the acknowledge slot, so the master sees no acknowledge on the ninth clock. It also corrupts the read-back byte in the same transfer. Errors in the pending selection appear only at the following stop, as a wrong or early `chan_en` value. For that reason the bench samples the enables both just before and just after every stop. A filter that is too short shows as an aborted or bit-shifted write, which is visible at that same stop.

// File: rtl/chsel_pkg.sv
package chsel_pkg;
   localparam int BYTE_W = 8;
   localparam int BITCNT_W = $clog2(BYTE_W + 1);

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_WDAT,
      ST_WACK,
      ST_RDAT,
      ST_RACK
   } chsel_state_t;
endpackage

// File: rtl/chsel_glitch.sv
module chsel_glitch #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_CYCLES = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic clean
);
   logic [SYNC_STAGES-1:0] sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
   end

   generate
      if (FILT_CYCLES == 0) begin : g_bypass
         assign clean = sync_q[SYNC_STAGES-1];
      end else begin : g_count
         localparam int CW = $clog2(FILT_CYCLES + 1);
         logic [CW-1:0] cnt_q;
         logic          lvl_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
               lvl_q <= 1'b1;
            end else if (sync_q[SYNC_STAGES-1] == lvl_q) begin
               cnt_q <= '0;
            end else if (cnt_q == CW'(FILT_CYCLES - 1)) begin
               cnt_q <= '0;
               lvl_q <= sync_q[SYNC_STAGES-1];
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
         assign clean = lvl_q;
      end
   endgenerate
endmodule

// File: rtl/chsel_busev.sv
module chsel_busev (
   input  logic clk,
   input  logic rst_n,
   input  logic scl,
   input  logic sda,
   output logic start_det,
   output logic stop_det,
   output logic scl_rise,
   output logic scl_fall
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl;
         sda_q <= sda;
      end
   end

   assign start_det = scl_q & scl & sda_q & ~sda;
   assign stop_det  = scl_q & scl & ~sda_q & sda;
   assign scl_rise  = ~scl_q & scl;
   assign scl_fall  = scl_q & ~scl;
endmodule

// File: rtl/chsel_ctrl.sv
module chsel_ctrl
   import chsel_pkg::*;
#(
   parameter int         NCH     = 4,
   parameter logic [3:0] ADDR_HI = 4'b1110
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start_det,
   input  logic           stop_det,
   input  logic           scl_rise,
   input  logic           scl_fall,
   input  logic           sda,
   input  logic [2:0]     strap,
   output logic           sda_low,
   output logic [NCH-1:0] chan_en,
   output logic           idle
);
   localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(BYTE_W);

   chsel_state_t          state;
   logic [BITCNT_W-1:0]   bitcnt;
   logic [BYTE_W-1:0]     shr;
   logic [BYTE_W-1:0]     tx;
   logic [BYTE_W-1:0]     rd_byte;
   logic                  rw;
   logic                  mack;
   logic [NCH-1:0]        pend;
   logic                  pend_v;

   always_comb begin
      rd_byte = '0;
      rd_byte[NCH-1:0] = chan_en;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         bitcnt  <= '0;
         shr     <= '0;
         tx      <= '0;
         rw      <= 1'b0;
         mack    <= 1'b0;
         pend    <= '0;
         pend_v  <= 1'b0;
         sda_low <= 1'b0;
         chan_en <= '0;
      end else if (stop_det) begin
         state   <= ST_IDLE;
         sda_low <= 1'b0;
         pend_v  <= 1'b0;
         if (pend_v) chan_en <= pend;
      end else if (start_det) begin
         state   <= ST_ADDR;
         bitcnt  <= '0;
         sda_low <= 1'b0;
      end else begin
         case (state)
            ST_ADDR: begin
               if (scl_rise) begin
                  shr    <= {shr[BYTE_W-2:0], sda};
                  bitcnt <= bitcnt + 1'b1;
               end else if (scl_fall && bitcnt == LAST_BIT) begin
                  if (shr[BYTE_W-1:1] == {ADDR_HI, strap}) begin
                     rw      <= shr[0];
                     sda_low <= 1'b1;
                     state   <= ST_AACK;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            ST_AACK: begin
               if (scl_fall) begin
                  bitcnt <= '0;
                  if (rw) begin
                     tx      <= {rd_byte[BYTE_W-2:0], 1'b0};
                     sda_low <= ~rd_byte[BYTE_W-1];
                     state   <= ST_RDAT;
                  end else begin
                     sda_low <= 1'b0;
                     state   <= ST_WDAT;
                  end
               end
            end
            ST_WDAT: begin
               if (scl_rise) begin
                  shr    <= {shr[BYTE_W-2:0], sda};
                  bitcnt <= bitcnt + 1'b1;
               end else if (scl_fall && bitcnt == LAST_BIT) begin
                  pend    <= shr[NCH-1:0];
                  pend_v  <= 1'b1;
                  sda_low <= 1'b1;
                  state   <= ST_WACK;
               end
            end
            ST_WACK: begin
               if (scl_fall) begin
                  sda_low <= 1'b0;
                  bitcnt  <= '0;
                  state   <= ST_WDAT;
               end
            end
            ST_RDAT: begin
               if (scl_rise) begin
                  bitcnt <= bitcnt + 1'b1;
               end else if (scl_fall) begin
                  if (bitcnt == LAST_BIT) begin
                     sda_low <= 1'b0;
                     state   <= ST_RACK;
                  end else begin
                     sda_low <= ~tx[BYTE_W-1];
                     tx      <= {tx[BYTE_W-2:0], 1'b0};
                  end
               end
            end
            ST_RACK: begin
               if (scl_rise) begin
                  mack <= ~sda;
               end else if (scl_fall) begin
                  if (mack) begin
                     tx      <= {rd_byte[BYTE_W-2:0], 1'b0};
                     sda_low <= ~rd_byte[BYTE_W-1];
                     bitcnt  <= '0;
                     state   <= ST_RDAT;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign idle = (state == ST_IDLE);
endmodule

// File: rtl/i2c_chan_sel.sv
module i2c_chan_sel #(
   parameter int         NCH         = 4,
   parameter int         SYNC_STAGES = 2,
   parameter int         FILT_CYCLES = 6,
   parameter logic [3:0] ADDR_HI     = 4'b1110
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [2:0]     strap,
   input  logic           scl_in,
   input  logic           sda_in,
   output logic           sda_low,
   output logic [NCH-1:0] chan_en
);
   localparam int NLINES = 2;

   generate
      if (NCH < 1 || NCH > 8) begin : g_bad_nch
         $error("NCH must lie in 1..8");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (FILT_CYCLES < 0) begin : g_bad_filt
         $error("FILT_CYCLES must not be negative");
      end
   endgenerate

   logic [NLINES-1:0] raw_lines;
   logic [NLINES-1:0] flt_lines;
   logic start_det, stop_det, scl_rise, scl_fall, idle;

   assign raw_lines = {sda_in, scl_in};

   generate
      for (genvar i = 0; i < NLINES; i++) begin : g_line
         chsel_glitch #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_CYCLES(FILT_CYCLES)
         ) u_flt (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (raw_lines[i]),
            .clean(flt_lines[i])
         );
      end
   endgenerate

   chsel_busev u_ev (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl      (flt_lines[0]),
      .sda      (flt_lines[1]),
      .start_det(start_det),
      .stop_det (stop_det),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall)
   );

   chsel_ctrl #(
      .NCH    (NCH),
      .ADDR_HI(ADDR_HI)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_det(start_det),
      .stop_det (stop_det),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .sda      (flt_lines[1]),
      .strap    (strap),
      .sda_low  (sda_low),
      .chan_en  (chan_en),
      .idle     (idle)
   );
endmodule

// File: rtl/chsel_chk.sv
module chsel_chk #(
   parameter int NCH = 4
) (
   input logic           clk,
   input logic           rst_n,
   input logic           sda_low,
   input logic [NCH-1:0] chan_en,
   input logic           start_det,
   input logic           stop_det,
   input logic           scl_fall,
   input logic           idle
);
   // R1: reset forces the enables to zero and releases data
   a_r1_reset_clears: assert property (@(posedge clk)
      !rst_n |=> (chan_en == '0 && !sda_low));

   // R4: enables move only on the edge after a stop was detected
   a_r4_update_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(chan_en) |-> $past(stop_det));

   // R3: the data driver changes only after a clock fall or a bus condition
   a_r3_drive_on_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_low) |-> $past(scl_fall || start_det || stop_det));

   // R2: no data drive while waiting for a start
   a_r2_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
      idle |-> !sda_low);

   // R8: a stop always returns the controller to idle
   a_r8_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> idle);
endmodule

bind i2c_chan_sel chsel_chk #(.NCH(NCH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sda_low  (sda_low),
   .chan_en  (chan_en),
   .start_det(start_det),
   .stop_det (stop_det),
   .scl_fall (scl_fall),
   .idle     (idle)
);

// File: tb/sim_i2c_chan_sel.sv
module sim_i2c_chan_sel;
   localparam int Q = 12;
   localparam int WATCHDOG = 195000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] strap = 3'b101;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       sda_low;
   logic [3:0] chan_en;
   logic       sda_bus;

   int nchk = 0;
   int nerr = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   assign sda_bus = sda_m & ~sda_low;

   i2c_chan_sel u0 (
      .clk    (clk),
      .rst_n  (rst_n),
      .strap  (strap),
      .scl_in (scl_m),
      .sda_in (sda_bus),
      .sda_low(sda_low),
      .chan_en(chan_en)
   );

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic bus_start;
      sda_m = 1'b1; wait_clk(Q);
      scl_m = 1'b1; wait_clk(2*Q);
      sda_m = 1'b0; wait_clk(2*Q);
      scl_m = 1'b0; wait_clk(Q);
   endtask

   task automatic bus_stop;
      sda_m = 1'b0; wait_clk(Q);
      scl_m = 1'b1; wait_clk(2*Q);
      sda_m = 1'b1; wait_clk(4*Q);
   endtask

   task automatic bit_io(input bit b, output bit s);
      sda_m = b;    wait_clk(Q);
      scl_m = 1'b1; wait_clk(Q);
      s = sda_bus;  wait_clk(Q);
      scl_m = 1'b0; wait_clk(Q);
   endtask

   task automatic send_byte(input logic [7:0] d, output bit ack);
      bit s;
      for (int i = 7; i >= 0; i--) bit_io(d[i], s);
      bit_io(1'b1, s);
      ack = ~s;
   endtask

   task automatic recv_byte(input bit mack, output logic [7:0] d);
      bit s;
      for (int i = 7; i >= 0; i--) begin
         bit_io(1'b1, s);
         d[i] = s;
      end
      bit_io(~mack, s);
   endtask

   function automatic logic [7:0] addr_w();
      return {4'b1110, strap, 1'b0};
   endfunction

   function automatic logic [7:0] addr_r();
      return {4'b1110, strap, 1'b1};
   endfunction

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         nerr++;
         $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

   initial begin
      bit         ack;
      logic [7:0] rd, rd2;
      logic [3:0] expv;

      // R1: reset state
      wait_clk(10);
      chk(chan_en == 4'h0, "R1 enables in reset", chan_en, 0);
      chk(sda_low == 1'b0, "R1 data released in reset", sda_low, 0);
      rst_n = 1'b1;
      wait_clk(10);
      expv = 4'h0;

      // R3 R4 R6: exhaustive sweep of the selection with varying upper nibble
      for (int v = 0; v < 16; v++) begin
         logic [7:0] d;
         d = {4'(v * 3 + 5), 4'(v)};
         bus_start;
         send_byte(addr_w(), ack);
         chk(ack, "R2 own address acked", ack, 1);
         send_byte(d, ack);
         chk(ack, "R3 data byte acked", ack, 1);
         chk(chan_en == expv, "R4 not applied before stop", chan_en, expv);
         bus_stop;
         expv = 4'(v);
         chk(chan_en == expv, "R3 applied at stop", chan_en, expv);
         bus_start;
         send_byte(addr_r(), ack);
         chk(ack, "R2 read address acked", ack, 1);
         recv_byte(1'b0, rd);
         bus_stop;
         chk(rd == {4'h0, expv}, "R6 read-back byte", rd, {4'h0, expv});
      end

      // R2: address sweep; data follows only when acknowledged
      expv = 4'h9;
      bus_start; send_byte(addr_w(), ack); send_byte(8'h09, ack); bus_stop;
      for (int a = 0; a < 128; a++) begin
         bit match;
         match = (7'(a) == {4'b1110, strap});
         bus_start;
         send_byte({7'(a), 1'b0}, ack);
         chk(ack == match, "R2 ack only on match", ack, match);
         if (ack) begin
            send_byte(8'h06, ack);
            expv = 4'h6;
         end
         bus_stop;
         chk(chan_en == expv, "R2 no effect unless addressed", chan_en, expv);
      end
      strap = 3'b010;
      wait_clk(4);
      bus_start; send_byte({4'b1110, 3'b101, 1'b0}, ack); bus_stop;
      chk(!ack, "R2 old strap address ignored", ack, 0);
      bus_start; send_byte(addr_w(), ack); send_byte(8'h03, ack); bus_stop;
      chk(ack, "R2 new strap address acked", ack, 1);
      chk(chan_en == 4'h3, "R2 new strap write applied", chan_en, 3);

      // R5: multi-byte write keeps the last byte
      bus_start; send_byte(addr_w(), ack);
      send_byte(8'h05, ack); send_byte(8'h0C, ack);
      chk(ack, "R5 second data byte acked", ack, 1);
      chk(chan_en == 4'h3, "R5 still old before stop", chan_en, 3);
      bus_stop;
      chk(chan_en == 4'hC, "R5 last byte applied", chan_en, 12);

      // R11: address-only write
      bus_start; send_byte(addr_w(), ack); bus_stop;
      chk(chan_en == 4'hC, "R11 address-only write no change", chan_en, 12);

      // R7: repeated start keeps pending, read returns old applied value
      bus_start; send_byte(addr_w(), ack); send_byte(8'h05, ack);
      bus_start; send_byte(addr_r(), ack);
      chk(ack, "R7 address after repeated start acked", ack, 1);
      recv_byte(1'b0, rd);
      chk(rd == 8'h0C, "R7 read shows applied value", rd, 8'h0C);
      bus_stop;
      chk(chan_en == 4'h5, "R7 pending applied at final stop", chan_en, 5);

      // R8: stop mid-byte, then start mid-byte
      bus_start; send_byte(addr_w(), ack);
      for (int i = 0; i < 4; i++) bit_io(1'b1, ack);
      bus_stop;
      chk(chan_en == 4'h5, "R8 stop mid-byte no change", chan_en, 5);
      bus_start; send_byte(addr_w(), ack);
      for (int i = 0; i < 3; i++) bit_io(1'b1, ack);
      bus_start; send_byte(addr_w(), ack);
      chk(ack, "R8 start mid-byte restarts address", ack, 1);
      send_byte(8'h0A, ack); bus_stop;
      chk(chan_en == 4'hA, "R8 write after restart", chan_en, 10);

      // R6: multi-byte read with master ACK
      bus_start; send_byte(addr_r(), ack);
      recv_byte(1'b1, rd); recv_byte(1'b0, rd2); bus_stop;
      chk(rd == 8'h0A, "R6 first read byte", rd, 8'h0A);
      chk(rd2 == 8'h0A, "R6 repeated read byte", rd2, 8'h0A);

      // R9: reset cuts a write off
      bus_start; send_byte(addr_w(), ack); send_byte(8'h03, ack);
      rst_n = 1'b0; wait_clk(3);
      chk(chan_en == 4'h0, "R1 reset clears applied enables", chan_en, 0);
      chk(sda_low == 1'b0, "R1 reset releases data", sda_low, 0);
      rst_n = 1'b1; wait_clk(3);
      bus_stop;
      chk(chan_en == 4'h0, "R9 pending dropped by reset", chan_en, 0);

      // R10: short pulses on both lines are rejected
      bus_start; send_byte(addr_w(), ack);
      scl_m = 1'b1; wait_clk(2); scl_m = 1'b0; wait_clk(Q);
      sda_m = 1'b0; wait_clk(Q);
      scl_m = 1'b1; wait_clk(4);
      sda_m = 1'b1; wait_clk(2); sda_m = 1'b0; wait_clk(2*Q - 6);
      scl_m = 1'b0; wait_clk(Q);
      for (int i = 6; i >= 0; i--) bit_io((8'h0F >> i) & 1, rd[0]);
      bit_io(1'b1, rd[0]);
      chk(rd[0] == 1'b0, "R10 ack after glitches", rd[0], 0);
      bus_stop;
      chk(chan_en == 4'hF, "R10 byte intact after glitches", chan_en, 15);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule